// File: doc/BRIEF.md
# Low-Power Debug Status Word

This block builds the 32-bit read-only status word that a debug access port returns to an external debugger. The word describes the power state of the processor core. Some fields are live: whether a low-power stop mode is armed for the next deep sleep, whether the system is running in very-low-power mode, and the core halt, deep-sleep and sleeping lines. Two fields are sticky. They record that the system has come back from a low-leakage stop or from a very-low-leakage stop. The debugger loses contact while the system is in either mode, so these flags must survive until the debugger has seen them.

A companion control register produces a one-cycle acknowledge strobe when the debugger writes 1 to its status-acknowledge bit. That strobe clears both sticky flags. A write of 0 produces no strobe, so it has no effect. The recovery sequences for the two leakage modes each produce a one-cycle set pulse. If a set pulse and the acknowledge strobe arrive in the same cycle, the set wins, so no exit event is lost. The bus access logic is outside this block, and so is the control register.

A second output gives a compact 2-bit summary of the core state for local logic.

Top module: `lpdbg_status_reg`

## Requirements
- R1: Bit 7 is 1 exactly when `pwr_mode_sel` holds 2 (very-low-power stop), 3 (low-leakage stop) or 4 (very-low-leakage stop). It is 0 for every other code, with no clock delay.
- R2: Bit 8 equals `vlp_active` in the same cycle and is never sticky.
- R3: Bits 6..0 equal `aux_status[6..0]` in the same cycle.
- R4: Bit 9 (low-leakage exit) becomes 1 on the clock edge that samples `ll_recover_set` high. Bit 10 (very-low-leakage exit) does the same with `vll_recover_set`.
- R5: While `exit_ack` is low, a set bit 9 or bit 10 stays 1, whatever the other inputs do.
- R6: A clock edge that samples `exit_ack` high clears both bit 9 and bit 10. A flag whose set pulse is high on that same edge stays 1.
- R7: Bits 16, 17 and 18 equal `core_halted`, `core_deepsleep` and `core_sleeping` in the same cycle.
- R8: Bits 15..11 and bits 31..19 always read 0.
- R9: `core_state` gives the core state as a code. It is 3 (halted) whenever `core_halted` is 1. Otherwise it is 2 (stop) when sleeping and deep-sleep are both 1, 1 (wait) when sleeping is 1 and deep-sleep is 0, and 0 (run) when sleeping is 0.
- R10: An active-low asynchronous `rst_n` clears bits 9 and 10. They keep their value across anything other than reset or acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| pwr_mode_sel | input | 3 | Stop-mode selection code for next deep sleep |
| vlp_active | input | 1 | System currently in very-low-power run/wait |
| ll_recover_set | input | 1 | One-cycle pulse from low-leakage recovery sequence |
| vll_recover_set | input | 1 | One-cycle pulse from very-low-leakage recovery sequence |
| exit_ack | input | 1 | One-cycle strobe from acknowledge write of 1 |
| core_halted | input | 1 | Core in debug halt |
| core_deepsleep | input | 1 | Core deep-sleep indication |
| core_sleeping | input | 1 | Core sleeping indication |
| aux_status | input | 7 | Other status bits passed into bits 6..0 |
| status_word | output | 32 | Assembled status word |
| core_state | output | 2 | 0 run, 1 wait, 2 stop, 3 halted |

## Verification
The bench uses the default parameters: a 3-bit mode code, 7 pass-through bits and two sticky exit flags. With a 3-bit mode code, random stimulus covers all eight mode codes, so every code is checked against the decode, including the codes above 4 that must not arm the stop indication. Two independent sticky flags sharing one acknowledge allow the bench to reach the case where one flag is set again on the acknowledge edge while the other is cleared.

// File: rtl/lpdbg_pkg.sv
package lpdbg_pkg;
  localparam int WORD_W = 32;
  localparam int AUX_W  = 7;

  // field positions decoded by the debugger
  localparam int POS_LPS_EN  = 7;
  localparam int POS_VLP     = 8;
  localparam int POS_LL_EXIT = 9;
  localparam int POS_VLL_EXIT= 10;
  localparam int POS_HALT    = 16;
  localparam int POS_DEEP    = 17;
  localparam int POS_SLEEP   = 18;

  // stop-mode selection codes that arm a low-power stop
  localparam int CODE_VLPS = 2;
  localparam int CODE_LLS  = 3;
  localparam int CODE_VLLS = 4;

  typedef enum logic [1:0] {
    CORE_RUN  = 2'd0,
    CORE_WAIT = 2'd1,
    CORE_STOP = 2'd2,
    CORE_HALT = 2'd3
  } core_state_e;
endpackage

// File: rtl/lpdbg_mode_decode.sv
module lpdbg_mode_decode #(
  parameter int MODE_W = 3
) (
  input  logic [MODE_W-1:0] mode_sel,
  output logic              stop_armed
);
  import lpdbg_pkg::*;

  always_comb begin
    stop_armed = 1'b0;
    if (mode_sel == MODE_W'(CODE_VLPS) ||
        mode_sel == MODE_W'(CODE_LLS)  ||
        mode_sel == MODE_W'(CODE_VLLS))
      stop_armed = 1'b1;
  end
endmodule

// File: rtl/lpdbg_exit_flags.sv
module lpdbg_exit_flags #(
  parameter int N_FLAGS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FLAGS-1:0] set_pulse,
  input  logic               ack,
  output logic [N_FLAGS-1:0] flags
);
  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flags[i] <= 1'b0;
      else if (set_pulse[i])
        flags[i] <= 1'b1;   // set has priority over acknowledge
      else if (ack)
        flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/lpdbg_core_state.sv
module lpdbg_core_state (
  input  logic       halted,
  input  logic       deepsleep,
  input  logic       sleeping,
  output logic [1:0] state
);
  import lpdbg_pkg::*;

  core_state_e st;

  always_comb begin
    if (halted)
      st = CORE_HALT;
    else if (sleeping && deepsleep)
      st = CORE_STOP;
    else if (sleeping)
      st = CORE_WAIT;
    else
      st = CORE_RUN;
  end

  assign state = st;
endmodule

// File: rtl/lpdbg_status_reg.sv
module lpdbg_status_reg #(
  parameter int MODE_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [MODE_W-1:0]             pwr_mode_sel,
  input  logic                          vlp_active,
  input  logic                          ll_recover_set,
  input  logic                          vll_recover_set,
  input  logic                          exit_ack,
  input  logic                          core_halted,
  input  logic                          core_deepsleep,
  input  logic                          core_sleeping,
  input  logic [lpdbg_pkg::AUX_W-1:0]   aux_status,
  output logic [lpdbg_pkg::WORD_W-1:0]  status_word,
  output logic [1:0]                    core_state
);
  import lpdbg_pkg::*;

  localparam int N_EXIT = 2;

  logic              stop_armed;
  logic [N_EXIT-1:0] exit_flags;

  lpdbg_mode_decode #(.MODE_W(MODE_W)) u_dec (
    .mode_sel   (pwr_mode_sel),
    .stop_armed (stop_armed)
  );

  lpdbg_exit_flags #(.N_FLAGS(N_EXIT)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_pulse ({vll_recover_set, ll_recover_set}),
    .ack       (exit_ack),
    .flags     (exit_flags)
  );

  lpdbg_core_state u_cst (
    .halted    (core_halted),
    .deepsleep (core_deepsleep),
    .sleeping  (core_sleeping),
    .state     (core_state)
  );

  always_comb begin
    status_word               = '0;   // reserved fields stay zero
    status_word[AUX_W-1:0]    = aux_status;
    status_word[POS_LPS_EN]   = stop_armed;
    status_word[POS_VLP]      = vlp_active;
    status_word[POS_LL_EXIT]  = exit_flags[0];
    status_word[POS_VLL_EXIT] = exit_flags[1];
    status_word[POS_HALT]     = core_halted;
    status_word[POS_DEEP]     = core_deepsleep;
    status_word[POS_SLEEP]    = core_sleeping;
  end
endmodule

// File: rtl/lpdbg_status_chk.sv
module lpdbg_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        vlp_active,
  input logic        ll_recover_set,
  input logic        vll_recover_set,
  input logic        exit_ack,
  input logic        core_halted,
  input logic [31:0] status_word,
  input logic [1:0]  core_state
);
  a_r2_vlp_live: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[8] == vlp_active);

  a_r4_ll_set: assert property (@(posedge clk) disable iff (!rst_n)
    ll_recover_set |=> status_word[9]);

  a_r4_vll_set: assert property (@(posedge clk) disable iff (!rst_n)
    vll_recover_set |=> status_word[10]);

  a_r5_ll_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[9] && !exit_ack) |=> status_word[9]);

  a_r5_vll_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[10] && !exit_ack) |=> status_word[10]);

  a_r6_ll_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_ack && !ll_recover_set) |=> !status_word[9]);

  a_r6_vll_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_ack && !vll_recover_set) |=> !status_word[10]);

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[15:11] == 5'd0 && status_word[31:19] == 13'd0);

  a_r9_halt_prio: assert property (@(posedge clk) disable iff (!rst_n)
    core_halted |-> core_state == 2'd3);
endmodule

bind lpdbg_status_reg lpdbg_status_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .vlp_active      (vlp_active),
  .ll_recover_set  (ll_recover_set),
  .vll_recover_set (vll_recover_set),
  .exit_ack        (exit_ack),
  .core_halted     (core_halted),
  .status_word     (status_word),
  .core_state      (core_state)
);

// File: tb/tb_lpdbg_status_reg.sv
module tb_lpdbg_status_reg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  pwr_mode_sel = '0;
  logic        vlp_active = 0, ll_recover_set = 0, vll_recover_set = 0, exit_ack = 0;
  logic        core_halted = 0, core_deepsleep = 0, core_sleeping = 0;
  logic [6:0]  aux_status = '0;
  logic [31:0] status_word;
  logic [1:0]  core_state;

  int checks = 0;
  int failures = 0;
  logic m_ll = 0, m_vll = 0;   // bench model of sticky flags
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpdbg_status_reg dut (.*);

  function automatic logic f_armed(input logic [2:0] m);
    return (m == 3'd2 || m == 3'd3 || m == 3'd4);
  endfunction

  function automatic logic [1:0] f_state(input logic h, d, s);
    if (h) return 2'd3;
    if (s && d) return 2'd2;
    if (s) return 2'd1;
    return 2'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare every field of the outputs against the model
  task automatic check_all();
    chk("R3 aux", {25'd0, status_word[6:0]}, {25'd0, aux_status});
    chk("R1 stop armed", {31'd0, status_word[7]}, {31'd0, f_armed(pwr_mode_sel)});
    chk("R2 vlp live", {31'd0, status_word[8]}, {31'd0, vlp_active});
    chk("R4/R5/R6 ll exit", {31'd0, status_word[9]}, {31'd0, m_ll});
    chk("R4/R5/R6 vll exit", {31'd0, status_word[10]}, {31'd0, m_vll});
    chk("R7 core bits", {29'd0, status_word[18:16]},
        {29'd0, core_sleeping, core_deepsleep, core_halted});
    chk("R8 reserved", {status_word[31:19], status_word[15:11]}, 32'd0);
    chk("R9 core state", {30'd0, core_state},
        {30'd0, f_state(core_halted, core_deepsleep, core_sleeping)});
  endtask

  // drive at negedge, check, then advance model at posedge
  task automatic step(input logic [2:0] m, input logic v, ls, vs, ack,
                      input logic h, d, s, input logic [6:0] ax);
    @(negedge clk);
    pwr_mode_sel = m; vlp_active = v; ll_recover_set = ls; vll_recover_set = vs;
    exit_ack = ack; core_halted = h; core_deepsleep = d; core_sleeping = s;
    aux_status = ax;
    #1 check_all();
    @(posedge clk);
    if (ls) m_ll = 1; else if (ack) m_ll = 0;
    if (vs) m_vll = 1; else if (ack) m_vll = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed = 32'h5eed_1a2b;
    void'($urandom(seed));
    #(CLK_PERIOD * 2 + 1);
    // R10: reset state
    chk("R10 reset flags", {30'd0, status_word[10:9]}, 32'd0);
    @(negedge clk); rst_n = 1;

    // R4 directed: set low-leakage flag
    step(3'd3, 0, 1, 0, 0, 0, 0, 0, 7'h00);
    // R5: hold while ack low, vll set too
    step(3'd0, 1, 0, 1, 0, 0, 1, 1, 7'h55);
    step(3'd7, 0, 0, 0, 0, 1, 0, 1, 7'h2a);
    // R6: ack with concurrent set of ll -> ll stays, vll clears
    step(3'd4, 0, 1, 0, 1, 0, 0, 1, 7'h7f);
    step(3'd2, 0, 0, 0, 0, 0, 0, 0, 7'h01);
    // R6: ack alone clears
    step(3'd1, 0, 0, 0, 1, 0, 0, 0, 7'h00);
    step(3'd5, 1, 0, 0, 0, 0, 0, 0, 7'h00);
    // R10: reset clears set flags
    step(3'd6, 0, 1, 1, 0, 0, 0, 0, 7'h00);
    step(3'd0, 0, 0, 0, 0, 0, 0, 0, 7'h00);
    @(negedge clk); rst_n = 0; m_ll = 0; m_vll = 0;
    #1 chk("R10 async clear", {30'd0, status_word[10:9]}, 32'd0);
    @(negedge clk); rst_n = 1;

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom();
      step(r[2:0], r[3], r[6:4] == 3'd0, r[9:7] == 3'd0, r[12:10] == 3'd0,
           r[13] & r[14], r[15], r[16], r[23:17]);
    end

    @(negedge clk);
    #1 check_all();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule